// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken by combining recent program-wide branch behaviour with the branch address. A shift register keeps the resolved directions of the most recent branches. Each lookup XORs that history with a slice of the branch address. The result selects one of a table of two-bit saturating counters. The same branch reached along different recent paths therefore trains different counters.

The fetch side presents a branch address on the lookup port. One cycle later the block returns a taken or not-taken guess together with the table index it used. The pipeline keeps that index with the branch. When the branch resolves, the pipeline hands the index and the real direction to the training port. Training moves the selected counter one step toward the outcome and shifts the outcome into the history. Because the stored index is used, the history shifts that happen while the branch is in flight have no effect on which counter is trained.

Top module: `gshare_predictor`

## Requirements
- R1: After a synchronous reset the history is all zeros, `pred_out_valid` is low, and every counter reads as weakly taken (binary 10), so the first lookups at any address return taken.
- R2: A lookup presented with `pred_valid` in cycle t returns `pred_out_valid` high in cycle t+1, with `pred_index` equal to the history XOR address bits [PC_LSB+HIST_W-1:PC_LSB] (bits [9:2] by default) as they stood in cycle t. With `pred_valid` low the next cycle has `pred_out_valid` low.
- R3: The guess is taken when the selected counter is 11 or 10, and not taken when it is 01 or 00.
- R4: A taken outcome moves the counter up by one and stops at 11. A not-taken outcome moves it down by one and stops at 00.
- R5: A counter at 11 still predicts taken after one not-taken outcome and predicts not taken after a second one. The behaviour from 00 mirrors this.
- R6: Each training request shifts the outcome (1 = taken) into history bit 0 and drops the top bit, at the clock edge that samples the request. A lookup in the same cycle uses the history from before the shift.
- R7: Training changes only the counter at the supplied `upd_index`. No index is recomputed from the current history, and every other counter keeps its value.
- R8: Training requests on consecutive cycles to the same index all take effect, with no step lost.
- R9: A lookup presented in the cycle after a training request sees the trained counter. A lookup in the same cycle as the request sees the value from before training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Lookup request |
| pred_pc | input | PC_W | Branch address for the lookup |
| pred_out_valid | output | 1 | Lookup result valid (one cycle after request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | HIST_W | Table index used by this lookup |
| upd_valid | input | 1 | Training request |
| upd_index | input | HIST_W | Index returned by the matching lookup |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench keeps the counter table and the history in software and aims every lookup at a chosen counter by XORing the wanted index with the modelled history. It drives counters into both saturated ends and out again. A design without saturation would wrap from 11 to 00 and flip its guess, and a design without hysteresis would flip after a single miss. Back-to-back training on one index, and a lookup in the cycle right after training, expose a missing write bypass: that design loses a step or returns a stale guess. A lookup and a training request in the same cycle, together with index checks on every result, catch history that shifts at the wrong edge, in the wrong direction, or that feeds the training port's index path. A reset in the middle of the run shows whether a design keeps the trained counters when it should return to weakly taken.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  // Weakly taken: the value every entry holds after reset.
  localparam ctr_t CTR_INIT = 2'b10;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    if (taken) n = (c == 2'b11) ? c : ctr_t'(c + 2'b01);
    else       n = (c == 2'b00) ? c : ctr_t'(c - 2'b01);
    return n;
  endfunction

  function automatic logic ctr_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= shift_bit;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
      end
    end
  endgenerate

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int RD_PORTS = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [RD_PORTS-1:0][IDX_W-1:0] rd_idx,
  output ctr_t [RD_PORTS-1:0]            rd_data,
  input  logic                           we,
  input  logic [IDX_W-1:0]               w_idx,
  input  ctr_t                           w_data
);

  localparam int DEPTH = 1 << IDX_W;

  // Counter storage: plain synchronous RAM, no reset.
  ctr_t mem [DEPTH];
  // One flag per entry: cleared by reset, set on first write.
  logic [DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_data;
  end

  always_ff @(posedge clk) begin
    if (rst)     written <= '0;
    else if (we) written[w_idx] <= 1'b1;
  end

  generate
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      ctr_t mem_q;
      logic wr_q;
      logic byp_q;
      ctr_t byp_val_q;

      always_ff @(posedge clk) begin
        mem_q <= mem[rd_idx[p]];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          wr_q      <= 1'b0;
          byp_q     <= 1'b0;
          byp_val_q <= CTR_INIT;
        end else begin
          wr_q      <= written[rd_idx[p]];
          byp_q     <= we && (w_idx == rd_idx[p]);
          byp_val_q <= w_data;
        end
      end

      // Write-first: a write at the same edge wins over the array.
      assign rd_data[p] = byp_q ? byp_val_q : (wr_q ? mem_q : CTR_INIT);
    end
  endgenerate

endmodule

// File: rtl/gshare_updater.sv
module gshare_updater
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_index,
  input  logic             upd_taken,
  output logic [IDX_W-1:0] rd_idx,
  input  ctr_t             rd_data,
  output logic             we,
  output logic [IDX_W-1:0] w_idx,
  output ctr_t             w_data
);

  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_taken;

  // Read stage: address goes straight to the table.
  assign rd_idx = upd_index;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
      s1_taken <= 1'b0;
    end else begin
      s1_valid <= upd_valid;
      s1_idx   <= upd_index;
      s1_taken <= upd_taken;
    end
  end

  // Write stage: step the counter just read.
  assign we     = s1_valid;
  assign w_idx  = s1_idx;
  assign w_data = ctr_step(rd_data, s1_taken);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_out_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_index,
  input  logic              upd_valid,
  input  logic [HIST_W-1:0] upd_index,
  input  logic              upd_taken
);

  localparam int PORT_PRED = 0;
  localparam int PORT_UPD  = 1;
  localparam int N_PORTS   = 2;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] look_idx;
  logic unused_pc_bits;

  logic [N_PORTS-1:0][HIST_W-1:0] tbl_rd_idx;
  ctr_t [N_PORTS-1:0]             tbl_rd_data;
  logic [HIST_W-1:0]              upd_rd_idx;
  logic                           tbl_we;
  logic [HIST_W-1:0]              tbl_w_idx;
  ctr_t                           tbl_w_data;

  assign unused_pc_bits = ^pred_pc;

  gshare_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (hist_q)
  );

  assign look_idx = hist_q ^ pred_pc[PC_LSB +: HIST_W];

  assign tbl_rd_idx[PORT_PRED] = look_idx;
  assign tbl_rd_idx[PORT_UPD]  = upd_rd_idx;

  gshare_pht #(.IDX_W(HIST_W), .RD_PORTS(N_PORTS)) u_pht (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (tbl_rd_idx),
    .rd_data (tbl_rd_data),
    .we      (tbl_we),
    .w_idx   (tbl_w_idx),
    .w_data  (tbl_w_data)
  );

  gshare_updater #(.IDX_W(HIST_W)) u_upd (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_index (upd_index),
    .upd_taken (upd_taken),
    .rd_idx    (upd_rd_idx),
    .rd_data   (tbl_rd_data[PORT_UPD]),
    .we        (tbl_we),
    .w_idx     (tbl_w_idx),
    .w_data    (tbl_w_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_out_valid <= 1'b0;
      pred_index     <= '0;
    end else begin
      pred_out_valid <= pred_valid;
      pred_index     <= look_idx;
    end
  end

  assign pred_taken = ctr_taken(tbl_rd_data[PORT_PRED]);

endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_valid,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_out_valid,
  input logic [HIST_W-1:0] pred_index,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] pc_slice;
  logic unused_chk_pc;
  assign pc_slice      = pred_pc[PC_LSB +: HIST_W];
  assign unused_chk_pc = ^pred_pc;

  // R1: leaving reset gives empty history and no result
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hist == '0) && !pred_out_valid);

  // R2: a request yields a result next cycle with the hashed index
  assert_lookup_index_R2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_out_valid && (pred_index == ($past(hist) ^ $past(pc_slice))));

  // R2: no request, no result
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !pred_out_valid);

  // R6: training shifts the outcome in at bit 0
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (hist[0] == $past(upd_taken)) &&
                  ((hist >> 1) == ($past(hist) & {1'b0, {(HIST_W-1){1'b1}}})));

  // R6: no training, history holds
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist));

endmodule

bind gshare_predictor gshare_checker #(
  .HIST_W (HIST_W),
  .PC_W   (PC_W),
  .PC_LSB (PC_LSB)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pred_valid     (pred_valid),
  .pred_pc        (pred_pc),
  .pred_out_valid (pred_out_valid),
  .pred_index     (pred_index),
  .upd_valid      (upd_valid),
  .upd_taken      (upd_taken),
  .hist           (hist_q)
);

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;

  localparam int HW    = 8;
  localparam int PW    = 32;
  localparam int LSB   = 2;
  localparam int DEPTH = 1 << HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          pred_valid = 1'b0;
  logic [PW-1:0] pred_pc = '0;
  logic          pred_out_valid;
  logic          pred_taken;
  logic [HW-1:0] pred_index;
  logic          upd_valid = 1'b0;
  logic [HW-1:0] upd_index = '0;
  logic          upd_taken = 1'b0;

  gshare_predictor #(.HIST_W(HW), .PC_W(PW), .PC_LSB(LSB)) u0 (
    .clk            (clk),
    .rst            (rst),
    .pred_valid     (pred_valid),
    .pred_pc        (pred_pc),
    .pred_out_valid (pred_out_valid),
    .pred_taken     (pred_taken),
    .pred_index     (pred_index),
    .upd_valid      (upd_valid),
    .upd_index      (upd_index),
    .upd_taken      (upd_taken)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [HW-1:0] idx;
    logic          tk;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [1:0]    m_ctr [DEPTH];
  logic [HW-1:0] m_hist;

  function automatic void check(input bit ok, input string tag, input string what,
                                input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
    end
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'b10;
    m_hist = '0;
  endfunction

  function automatic logic [1:0] model_step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  // Address whose lookup lands on idx under the current modelled history.
  function automatic logic [PW-1:0] pc_for(input logic [HW-1:0] idx);
    logic [PW-1:0] pc;
    pc = $urandom;
    pc[LSB +: HW] = idx ^ m_hist;
    return pc;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done && pred_out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "result without request", 1, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pred_index == e.idx, t, "index", int'(pred_index), int'(e.idx));
        check(pred_taken == e.tk,  t, "taken", int'(pred_taken), int'(e.tk));
      end
    end
  end

  // Driver: one cycle of stimulus, expectations pushed before model training.
  task automatic drive(input bit pv, input logic [PW-1:0] pc, input bit uv,
                       input logic [HW-1:0] ui, input bit ut, input string tag);
    logic [HW-1:0] idx;
    @(negedge clk);
    pred_valid = pv;
    pred_pc    = pc;
    upd_valid  = uv;
    upd_index  = ui;
    upd_taken  = ut;
    if (pv) begin
      idx = m_hist ^ pc[LSB +: HW];
      exp_q.push_back('{idx: idx, tk: m_ctr[idx][1]});
      tag_q.push_back(tag);
    end
    if (uv) begin
      m_ctr[ui] = model_step(m_ctr[ui], ut);
      m_hist    = {m_hist[HW-2:0], ut};
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, '0, 1'b0, "");
  endtask

  task automatic look(input logic [HW-1:0] idx, input string tag);
    drive(1'b1, pc_for(idx), 1'b0, '0, 1'b0, tag);
  endtask

  task automatic train(input logic [HW-1:0] idx, input bit t);
    drive(1'b0, '0, 1'b1, idx, t, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst        = 1'b1;
    pred_valid = 1'b0;
    upd_valid  = 1'b0;
    model_reset();
    exp_q.delete();
    tag_q.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pred_out_valid == 1'b0, "R1", "valid after reset", int'(pred_out_valid), 0);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finish_up();
    end
  end

  initial begin
    do_reset();

    // R1 / R2: fresh table, zero history, plain addresses
    for (int i = 0; i < 6; i++) drive(1'b1, $urandom, 1'b0, '0, 1'b0, "R1");
    drive(1'b1, 32'h0000_03FC, 1'b0, '0, 1'b0, "R2");
    idle(1);
    drive(1'b0, 32'h0000_0010, 1'b0, '0, 1'b0, "R2");
    idle(2);

    // R4 / R3: climb to the top and stay there
    for (int i = 0; i < 3; i++) begin
      train(8'h5A, 1'b1);
      look(8'h5A, "R4");
    end
    // R5: one miss keeps taken, the second flips
    train(8'h5A, 1'b0);
    look(8'h5A, "R5");
    train(8'h5A, 1'b0);
    look(8'h5A, "R5");
    // R4: down to the floor and stay there
    for (int i = 0; i < 3; i++) begin
      train(8'h5A, 1'b0);
      look(8'h5A, "R4");
    end
    // R5 / R3: mirror from 00
    train(8'h5A, 1'b1);
    look(8'h5A, "R3");
    train(8'h5A, 1'b1);
    look(8'h5A, "R3");
    idle(2);

    // R7: only the named index moves
    train(8'h11, 1'b0);
    train(8'h11, 1'b0);
    look(8'h12, "R7");
    look(8'h10, "R7");
    look(8'h11, "R7");
    idle(2);

    // R8: back-to-back training on one index
    train(8'h33, 1'b0);
    train(8'h33, 1'b0);
    train(8'h33, 1'b0);
    look(8'h33, "R8");
    train(8'h34, 1'b1);
    train(8'h34, 1'b1);
    train(8'h34, 1'b0);
    look(8'h34, "R8");
    idle(2);

    // R9 / R6: lookup and training in the same cycle, then right after
    drive(1'b1, pc_for(8'h40), 1'b1, 8'h40, 1'b0, "R9");
    drive(1'b1, pc_for(8'h40), 1'b1, 8'h40, 1'b0, "R9");
    look(8'h40, "R9");
    idle(2);

    // R6: history pattern shows up in the index of a zero address
    train(8'h70, 1'b1);
    train(8'h71, 1'b0);
    train(8'h72, 1'b1);
    train(8'h73, 1'b1);
    drive(1'b1, 32'h0, 1'b0, '0, 1'b0, "R6");
    idle(1);
    for (int i = 0; i < 10; i++) train(8'hC0, 1'b1);
    drive(1'b1, 32'h0, 1'b0, '0, 1'b0, "R6");
    idle(2);

    // R8 / R9: random mix concentrated on a few counters
    for (int i = 0; i < 2000; i++) begin
      bit            pv;
      bit            uv;
      logic [HW-1:0] li;
      logic [HW-1:0] ui;
      pv = ($urandom_range(0, 2) != 0);
      uv = ($urandom_range(0, 1) != 0);
      li = HW'($urandom_range(0, 3));
      ui = HW'($urandom_range(0, 3));
      drive(pv, pc_for(li), uv, ui, 1'($urandom_range(0, 1)), "R8");
    end
    idle(3);

    // R1: reset in mid-run returns everything to weakly taken
    do_reset();
    for (int i = 0; i < 4; i++) drive(1'b1, 32'(i) << LSB, 1'b0, '0, 1'b0, "R1");
    idle(4);

    check(exp_q.size() == 0, "R2", "results outstanding", exp_q.size(), 0);
    finish_up();
  end

endmodule